// File: doc/BRIEF.md
# UART Software Flow-Control Character Injector

This block decides when a UART must tell its link partner to pause or resume sending, and places the matching flow-control characters into the local transmit stream. It watches how full the local receive FIFO is. When the fill level climbs above an upper threshold, it queues a two-character pause sequence. When the level later drops back to a lower threshold, it queues a two-character resume sequence. The gap between the two thresholds gives hysteresis, so the block does not chatter between pause and resume.

The transmit shifter offers a slot with a one-cycle pulse each time it reaches a character boundary and can take the next character. At each slot the block hands over exactly one character, or nothing. A pending flow character always wins the slot over the next transmit FIFO byte. The two characters of a sequence go out in consecutive slots, with no FIFO data between them. Flow characters are cut to the programmed word length. If software flow control is switched off while a pause is outstanding, the block sends the resume sequence on its own. The block assumes that hardware handshake flow control is never active at the same time.

Top module: `uart_flowctl_inject`

## Requirements
- R1: While reset is high and in the first cycle after it, `ld_valid`, `ld_flow` and `fifo_pop` are 0 and `xoff_active` is 0.
- R2: With `sw_fc_en` high and no pause outstanding, a receive level strictly greater than `trig_hi` queues the pause sequence: `xoff_c1` goes out at the next slot and `xoff_c2` at the slot after it. A level equal to `trig_hi` queues nothing.
- R3: With a pause outstanding, a receive level less than or equal to `trig_lo` queues the resume sequence `xon_c1` then `xon_c2`. A level of `trig_lo`+1 queues nothing.
- R4: `xoff_active` goes to 1 in the same edge that loads `xoff_c2`, and goes to 0 in the same edge that loads `xon_c2`. No pause sequence is queued while `xoff_active` is 1, and no resume sequence is queued while it is 0.
- R5: If `sw_fc_en` is low while `xoff_active` is 1, the resume sequence is queued whatever the level. While `sw_fc_en` is low and `xoff_active` is 0, no pause sequence is queued at any level.
- R6: Flow characters are truncated to the word length. `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. On `ld_data`, bits at and above the selected width are 0 and the lower bits equal the programmed character. FIFO bytes pass through unchanged.
- R7: A slot taken by a pending flow character asserts `ld_flow` and keeps `fifo_pop` low, even when `fifo_valid` is high. The second character of a sequence is loaded at the very next slot.
- R8: A load (`ld_valid`=1 for one cycle) occurs only in the cycle after a `tx_slot` pulse. If no flow character is pending and `fifo_valid` is high, that load carries `fifo_data` with `fifo_pop`=1 and `ld_flow`=0. If neither is available, no load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_fc_en | input | 1 | Software flow control enable |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| trig_hi | input | TRIG_W | Upper threshold; pause when level exceeds it |
| trig_lo | input | TRIG_W | Lower threshold; resume when level is at or below it |
| xoff_c1 | input | CHAR_W | First pause character |
| xoff_c2 | input | CHAR_W | Second pause character |
| xon_c1 | input | CHAR_W | First resume character |
| xon_c2 | input | CHAR_W | Second resume character |
| word_len | input | 2 | Word length code (0..3 = 5..8 bits) |
| tx_slot | input | 1 | One-cycle pulse: shifter at a character boundary, will take one character |
| fifo_valid | input | 1 | Transmit FIFO has a byte available |
| fifo_data | input | CHAR_W | Head byte of the transmit FIFO |
| ld_valid | output | 1 | Character load strobe to the shifter |
| ld_data | output | CHAR_W | Character being loaded |
| ld_flow | output | 1 | Loaded character is a flow-control character |
| fifo_pop | output | 1 | Consume the transmit FIFO head byte |
| xoff_active | output | 1 | A pause has been sent and not yet cancelled |

## Verification
The bench probes the edges of both thresholds. A level equal to the upper threshold must not pause, and a level one above the lower threshold must not resume. An off-by-one comparator would fail one of these probes. It holds the level high after a pause has gone out and offers more slots. A design without the outstanding flag would then send the pause again. The bench keeps FIFO data valid during every flow sequence, so a design that lets the FIFO win a slot, or lets a byte slip between the two characters, would show a popped byte where a flow character belongs. It also turns flow control off while a pause is outstanding, which must produce a resume sequence. Finally, it loads characters with high bits set at 5-bit and 7-bit word lengths, so a missing or shifted truncation mask leaks those bits onto the load.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FIRST  = 2'd1,
    SQ_SECOND = 2'd2
  } seq_t;

  typedef enum logic {
    FK_XOFF = 1'b0,
    FK_XON  = 1'b1
  } kind_t;

  localparam int MIN_WORD_BITS = 5;
endpackage

// File: rtl/uart_fc_monitor.sv
module uart_fc_monitor #(
  parameter int LVL_W  = 7,
  parameter int TRIG_W = 4
) (
  input  logic              sw_fc_en,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [TRIG_W-1:0] trig_hi,
  input  logic [TRIG_W-1:0] trig_lo,
  input  logic              xoff_active,
  output logic              need_xoff,
  output logic              need_xon
);
  logic [LVL_W-1:0] hi_ext, lo_ext;

  always_comb begin
    hi_ext    = LVL_W'(trig_hi);
    lo_ext    = LVL_W'(trig_lo);
    need_xoff = sw_fc_en && !xoff_active && (rx_level > hi_ext);
    need_xon  = xoff_active && (!sw_fc_en || (rx_level <= lo_ext));
  end
endmodule

// File: rtl/uart_fc_sequencer.sv
module uart_fc_sequencer
  import uart_fc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              need_xoff,
  input  logic              need_xon,
  input  logic              fc_take,
  input  logic [CHAR_W-1:0] xoff_c1,
  input  logic [CHAR_W-1:0] xoff_c2,
  input  logic [CHAR_W-1:0] xon_c1,
  input  logic [CHAR_W-1:0] xon_c2,
  output logic              fc_pending,
  output logic [CHAR_W-1:0] fc_char,
  output logic              xoff_active
);
  seq_t  state;
  kind_t kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      kind        <= FK_XOFF;
      xoff_active <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (need_xoff) begin
            state <= SQ_FIRST;
            kind  <= FK_XOFF;
          end else if (need_xon) begin
            state <= SQ_FIRST;
            kind  <= FK_XON;
          end
        end
        SQ_FIRST: if (fc_take) state <= SQ_SECOND;
        SQ_SECOND: begin
          if (fc_take) begin
            state       <= SQ_IDLE;
            xoff_active <= (kind == FK_XOFF);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    fc_pending = (state != SQ_IDLE);
    unique case ({kind, state == SQ_SECOND})
      2'b00:   fc_char = xoff_c1;
      2'b01:   fc_char = xoff_c2;
      2'b10:   fc_char = xon_c1;
      default: fc_char = xon_c2;
    endcase
  end

  AST_NO_REPEAT_XOFF: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FIRST && kind == FK_XOFF) |-> !xoff_active); // R4
  AST_NO_SPURIOUS_XON: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FIRST && kind == FK_XON) |-> xoff_active); // R4
  AST_FLAG_AT_SEQ_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(xoff_active) |-> ($past(state) == SQ_SECOND && $past(fc_take))); // R4
endmodule

// File: rtl/uart_fc_txmux.sv
module uart_fc_txmux
  import uart_fc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_slot,
  input  logic [1:0]        word_len,
  input  logic              fc_pending,
  input  logic [CHAR_W-1:0] fc_char,
  input  logic              fifo_valid,
  input  logic [CHAR_W-1:0] fifo_data,
  output logic              fc_take,
  output logic              ld_valid,
  output logic [CHAR_W-1:0] ld_data,
  output logic              ld_flow,
  output logic              fifo_pop
);
  logic [CHAR_W-1:0] width_mask;
  int                keep_bits;

  always_comb begin
    keep_bits = MIN_WORD_BITS + int'(word_len);
    for (int i = 0; i < CHAR_W; i++) width_mask[i] = (i < keep_bits);
    fc_take = tx_slot && fc_pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_flow  <= 1'b0;
      fifo_pop <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= 1'b0;
      ld_flow  <= 1'b0;
      fifo_pop <= 1'b0;
      if (tx_slot) begin
        if (fc_pending) begin
          ld_valid <= 1'b1;
          ld_flow  <= 1'b1;
          ld_data  <= fc_char & width_mask;
        end else if (fifo_valid) begin
          ld_valid <= 1'b1;
          fifo_pop <= 1'b1;
          ld_data  <= fifo_data;
        end
      end
    end
  end

  AST_LOAD_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(tx_slot)); // R8
  AST_FLOW_BLOCKS_POP: assert property (@(posedge clk) disable iff (rst)
    ld_flow |-> (ld_valid && !fifo_pop)); // R7
  AST_FLOW_WINS_SLOT: assert property (@(posedge clk) disable iff (rst)
    (tx_slot && fc_pending) |=> (ld_valid && ld_flow)); // R7
  AST_FIVE_BIT_TRUNC: assert property (@(posedge clk) disable iff (rst)
    (ld_flow && $past(word_len) == 2'd0) |-> (ld_data[CHAR_W-1:MIN_WORD_BITS] == '0)); // R6
endmodule

// File: rtl/uart_flowctl_inject.sv
module uart_flowctl_inject #(
  parameter int LVL_W  = 7,
  parameter int TRIG_W = 4,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_fc_en,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [TRIG_W-1:0] trig_hi,
  input  logic [TRIG_W-1:0] trig_lo,
  input  logic [CHAR_W-1:0] xoff_c1,
  input  logic [CHAR_W-1:0] xoff_c2,
  input  logic [CHAR_W-1:0] xon_c1,
  input  logic [CHAR_W-1:0] xon_c2,
  input  logic [1:0]        word_len,
  input  logic              tx_slot,
  input  logic              fifo_valid,
  input  logic [CHAR_W-1:0] fifo_data,
  output logic              ld_valid,
  output logic [CHAR_W-1:0] ld_data,
  output logic              ld_flow,
  output logic              fifo_pop,
  output logic              xoff_active
);
  logic              need_xoff, need_xon, fc_take, fc_pending;
  logic [CHAR_W-1:0] fc_char;

  uart_fc_monitor #(.LVL_W(LVL_W), .TRIG_W(TRIG_W)) u_mon (
    .sw_fc_en(sw_fc_en), .rx_level(rx_level), .trig_hi(trig_hi),
    .trig_lo(trig_lo), .xoff_active(xoff_active),
    .need_xoff(need_xoff), .need_xon(need_xon)
  );

  uart_fc_sequencer #(.CHAR_W(CHAR_W)) u_seq (
    .clk(clk), .rst(rst), .need_xoff(need_xoff), .need_xon(need_xon),
    .fc_take(fc_take), .xoff_c1(xoff_c1), .xoff_c2(xoff_c2),
    .xon_c1(xon_c1), .xon_c2(xon_c2), .fc_pending(fc_pending),
    .fc_char(fc_char), .xoff_active(xoff_active)
  );

  uart_fc_txmux #(.CHAR_W(CHAR_W)) u_mux (
    .clk(clk), .rst(rst), .tx_slot(tx_slot), .word_len(word_len),
    .fc_pending(fc_pending), .fc_char(fc_char), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fc_take(fc_take), .ld_valid(ld_valid),
    .ld_data(ld_data), .ld_flow(ld_flow), .fifo_pop(fifo_pop)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!ld_valid && !fifo_pop && !xoff_active)); // R1
endmodule

// File: tb/uart_flowctl_inject_tb.sv
module uart_flowctl_inject_tb;
  localparam int LVL_W = 7;
  localparam int CW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sw_fc_en = 1'b1;
  logic [LVL_W-1:0] rx_level = '0;
  logic [3:0]    trig_hi = 4'd8, trig_lo = 4'd3;
  logic [CW-1:0] xoff_c1 = 8'h93, xoff_c2 = 8'hE5, xon_c1 = 8'h91, xon_c2 = 8'hB1;
  logic [1:0]    word_len = 2'd3;
  logic          tx_slot = 1'b0, fifo_valid = 1'b0;
  logic [CW-1:0] fifo_data = 8'h00;
  logic          ld_valid, ld_flow, fifo_pop, xoff_active;
  logic [CW-1:0] ld_data;

  int total = 0, bad = 0;
  logic          s_valid, s_flow, s_pop;
  logic [CW-1:0] s_data;

  always #2.5 clk = ~clk;

  uart_flowctl_inject #(.LVL_W(LVL_W), .TRIG_W(4), .CHAR_W(CW)) u_dut (
    .clk(clk), .rst(rst), .sw_fc_en(sw_fc_en), .rx_level(rx_level),
    .trig_hi(trig_hi), .trig_lo(trig_lo), .xoff_c1(xoff_c1), .xoff_c2(xoff_c2),
    .xon_c1(xon_c1), .xon_c2(xon_c2), .word_len(word_len), .tx_slot(tx_slot),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .ld_valid(ld_valid),
    .ld_data(ld_data), .ld_flow(ld_flow), .fifo_pop(fifo_pop),
    .xoff_active(xoff_active)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] trunc(input logic [CW-1:0] c, input logic [1:0] wl);
    int n = 5 + int'(wl);
    logic [CW-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = c[i];
    return r;
  endfunction

  task automatic set_level(input int lvl);
    @(negedge clk);
    rx_level = LVL_W'(lvl);
    @(negedge clk);
  endtask

  task automatic slot();
    @(negedge clk);
    tx_slot = 1'b1;
    @(negedge clk);
    tx_slot = 1'b0;
    s_valid = ld_valid; s_flow = ld_flow; s_pop = ld_pop_w(); s_data = ld_data;
  endtask

  function automatic logic ld_pop_w();
    return fifo_pop;
  endfunction

  task automatic expect_fifo(input string req, input logic [CW-1:0] b);
    fifo_valid = 1'b1; fifo_data = b;
    slot();
    chk(req, "fifo load valid", s_valid, 1);
    chk(req, "fifo load flow", s_flow, 0);
    chk(req, "fifo pop", s_pop, 1);
    chk(req, "fifo data", s_data, b);
  endtask

  task automatic expect_flow(input string req, input logic [CW-1:0] c);
    fifo_valid = 1'b1; fifo_data = 8'hC7;
    slot();
    chk(req, "flow valid", s_valid, 1);
    chk(req, "flow flag", s_flow, 1);
    chk(req, "flow no pop", s_pop, 0);
    chk(req, "flow char", s_data, trunc(c, word_len));
  endtask

  task automatic t_reset();
    chk("R1", "ld_valid in reset", ld_valid, 0);
    chk("R1", "xoff_active in reset", xoff_active, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "ld_valid after reset", ld_valid, 0);
    chk("R1", "fifo_pop after reset", fifo_pop, 0);
    chk("R1", "xoff_active after reset", xoff_active, 0);
  endtask

  task automatic t_passthrough();
    expect_fifo("R8", 8'h5A);
    expect_fifo("R8", 8'hFF);
    fifo_valid = 1'b0;
    slot();
    chk("R8", "empty slot no load", s_valid, 0);
    fifo_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "no slot no load", ld_valid, 0);
    chk("R8", "no slot no pop", fifo_pop, 0);
  endtask

  task automatic t_xoff();
    set_level(8);
    expect_fifo("R2", 8'h11);
    set_level(9);
    expect_flow("R2", xoff_c1);
    chk("R4", "flag before second char", xoff_active, 0);
    expect_flow("R7", xoff_c2);
    chk("R4", "flag after XOFF2", xoff_active, 1);
    expect_fifo("R7", 8'h22);
    set_level(15);
    expect_fifo("R4", 8'h33);
    expect_fifo("R4", 8'h34);
  endtask

  task automatic t_xon();
    set_level(4);
    expect_fifo("R3", 8'h44);
    set_level(3);
    expect_flow("R3", xon_c1);
    expect_flow("R3", xon_c2);
    chk("R4", "flag after XON2", xoff_active, 0);
    set_level(0);
    expect_fifo("R4", 8'h55);
  endtask

  task automatic t_trunc();
    word_len = 2'd0;
    set_level(12);
    expect_flow("R6", xoff_c1);
    expect_flow("R6", xoff_c2);
    word_len = 2'd2;
    set_level(2);
    expect_flow("R6", xon_c1);
    expect_flow("R6", xon_c2);
    word_len = 2'd3;
    expect_fifo("R6", 8'hE7);
  endtask

  task automatic t_disable();
    set_level(10);
    expect_flow("R5", xoff_c1);
    expect_flow("R5", xoff_c2);
    chk("R5", "flag set before disable", xoff_active, 1);
    sw_fc_en = 1'b0;
    @(negedge clk);
    expect_flow("R5", xon_c1);
    expect_flow("R5", xon_c2);
    chk("R5", "flag cleared by auto XON", xoff_active, 0);
    set_level(14);
    expect_fifo("R5", 8'h66);
    chk("R5", "disabled stays clear", xoff_active, 0);
    sw_fc_en = 1'b1;
    @(negedge clk);
    expect_flow("R2", xoff_c1);
    expect_flow("R2", xoff_c2);
  endtask

  initial begin
    s_valid = 0; s_flow = 0; s_pop = 0; s_data = '0;
    t_reset();
    t_passthrough();
    t_xoff();
    t_xon();
    t_trunc();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule